// File: doc/BRIEF.md
# Repeater Port Auto-Partition State Machine

This block watches one port of a shared-medium repeater and decides whether the port is allowed to feed traffic into the repeater core. A port that keeps colliding, holds a collision for too long, or (at 100 Mb/s) starts jabbering is isolated. While isolated, its receive path is gated off: the port is still monitored and repeated traffic is still sent out to it, but nothing it receives is repeated. The port is taken back into service once it carries a clean, collision-free transfer longer than 512 bit times, in either direction.

All time limits are counted in bit times through a one-cycle strobe input, so the same logic serves a 10 Mb/s or a 100 Mb/s port. A speed input picks the consecutive-collision limit (32 or 64 by default), and two control inputs double the limit for each speed. Separate disable inputs switch isolation off for each speed. A packet is one unbroken stretch of activity, where activity is receive carrier or port transmit.

Top module: `port_isolation_fsm`

## Requirements
- R1: After reset, `isolated` is 0 and `rx_gate` is 1.
- R2: A packet that ends after seeing `collision` adds one to a consecutive-collision count; the port is isolated when a packet ends that brings the count to the limit: 32 with `speed_100`=0, 64 with `speed_100`=1.
- R3: `limit_x2_10`=1 raises the 10 Mb/s limit to 64; `limit_x2_100`=1 raises the 100 Mb/s limit to 128; each bit has no effect on the other speed.
- R4: A packet that ends without any collision clears the consecutive-collision count to zero.
- R5: A collision held for more than 1024 bit-time strobes isolates the port on the strobe that exceeds 1024, before the collision ends; 1024 strobes do not.
- R6: With `speed_100`=1, `jabber`=1 isolates the port in the next cycle; with `speed_100`=0, `jabber` has no effect.
- R7: An isolated port is reconnected when a packet (carrier or port transmit) ends having lasted at least 513 strobes with no collision; a clean packet of 512 strobes, or any collided packet, leaves it isolated.
- R8: `rx_gate` is 0 exactly while `isolated` is 1.
- R9: `part_dis_10`=1 prevents isolation while `speed_100`=0 and `part_dis_100`=1 prevents it while `speed_100`=1; neither affects the other speed.
- R10: Only cycles with `bit_tick`=1 advance the length and collision-duration counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| carrier | input | 1 | Receive activity on the port |
| port_tx | input | 1 | Repeater is transmitting on the port |
| collision | input | 1 | Collision involving the port |
| jabber | input | 1 | Port is in the jabber state |
| speed_100 | input | 1 | 1: 100 Mb/s limits, 0: 10 Mb/s limits |
| limit_x2_10 | input | 1 | Double the 10 Mb/s collision limit |
| limit_x2_100 | input | 1 | Double the 100 Mb/s collision limit |
| part_dis_10 | input | 1 | Disable isolation at 10 Mb/s |
| part_dis_100 | input | 1 | Disable isolation at 100 Mb/s |
| isolated | output | 1 | Port is partitioned |
| rx_gate | output | 1 | Receive path enable into the repeater |

## Verification
Every result is registered once: a packet that ends in cycle N (activity low with it high in N-1) changes `isolated` after the clock edge that closes cycle N, a jabber or the 1025th collision strobe changes it after the edge of that same cycle. The bench drives inputs on the falling edge and samples on the next falling edge, so each check lands half a cycle after the single register that can change. The boundary checks sample one strobe before and one strobe at each threshold (31/32, 63/64, 127/128 packets, 1024/1025 collision strobes, 512/513 clean strobes).

// File: rtl/port_iso_pkg.sv
package port_iso_pkg;
    localparam int CC_W = 8;

    typedef struct packed {
        logic            isolated;
        logic            act;
        logic            saw_col;
        logic [CC_W-1:0] cc;
    } iso_state_t;
endpackage

// File: rtl/iso_tick_counter.sv
module iso_tick_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAX = '1;

    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clear)
            count_d = '0;
        else if (inc && count_q != MAX)
            count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

    assert_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count_q) == MAX && !$past(clear)) |-> count_q == MAX);
endmodule

// File: rtl/cc_limit_sel.sv
module cc_limit_sel #(
    parameter int W       = 8,
    parameter int BASE10  = 32,
    parameter int BASE100 = 64
) (
    input  logic         speed_100,
    input  logic         x2_10,
    input  logic         x2_100,
    output logic [W-1:0] limit
);
    localparam logic [W-1:0] L10  = W'(BASE10);
    localparam logic [W-1:0] L100 = W'(BASE100);

    always_comb begin
        if (speed_100) limit = x2_100 ? (L100 << 1) : L100;
        else           limit = x2_10  ? (L10  << 1) : L10;
    end
endmodule

// File: rtl/port_isolation_fsm.sv
module port_isolation_fsm
    import port_iso_pkg::*;
#(
    parameter int BASE_LIMIT_10  = 32,
    parameter int BASE_LIMIT_100 = 64,
    parameter int LONG_COL_BITS  = 1024,
    parameter int RECON_BITS     = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic carrier,
    input  logic port_tx,
    input  logic collision,
    input  logic jabber,
    input  logic speed_100,
    input  logic limit_x2_10,
    input  logic limit_x2_100,
    input  logic part_dis_10,
    input  logic part_dis_100,
    output logic isolated,
    output logic rx_gate
);
    localparam int COLRUN_W = $clog2(LONG_COL_BITS + 2);
    localparam int LEN_W    = $clog2(RECON_BITS + 2);
    localparam logic [COLRUN_W-1:0] LONG_TH  = COLRUN_W'(LONG_COL_BITS);
    localparam logic [LEN_W-1:0]    RECON_TH = LEN_W'(RECON_BITS);
    localparam logic [CC_W-1:0]     CC_MAX   = '1;

    iso_state_t st_d, st_q;

    logic                activity;
    logic                pkt_end;
    logic                dis_now;
    logic                long_hit;
    logic                jab_hit;
    logic [CC_W-1:0]     cc_inc;
    logic [CC_W-1:0]     limit;
    logic [COLRUN_W-1:0] colrun;
    logic [LEN_W-1:0]    pkt_len;

    assign activity = carrier | port_tx;

    iso_tick_counter #(.W(COLRUN_W)) colrun_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!collision),
        .inc   (bit_tick),
        .count (colrun)
    );

    iso_tick_counter #(.W(LEN_W)) len_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!activity),
        .inc   (bit_tick),
        .count (pkt_len)
    );

    cc_limit_sel #(
        .W       (CC_W),
        .BASE10  (BASE_LIMIT_10),
        .BASE100 (BASE_LIMIT_100)
    ) limit_i (
        .speed_100 (speed_100),
        .x2_10     (limit_x2_10),
        .x2_100    (limit_x2_100),
        .limit     (limit)
    );

    always_comb begin
        pkt_end  = st_q.act && !activity;
        dis_now  = speed_100 ? part_dis_100 : part_dis_10;
        long_hit = collision && bit_tick && (colrun >= LONG_TH);
        jab_hit  = speed_100 && jabber;
        cc_inc   = (st_q.cc == CC_MAX) ? st_q.cc : st_q.cc + 1'b1;

        st_d         = st_q;
        st_d.act     = activity;
        st_d.saw_col = activity && (st_q.saw_col || collision);

        if (pkt_end) begin
            if (st_q.saw_col) begin
                st_d.cc = cc_inc;
                if (cc_inc >= limit) st_d.isolated = 1'b1;
            end else begin
                st_d.cc = '0;
                if (st_q.isolated && pkt_len > RECON_TH) st_d.isolated = 1'b0;
            end
        end

        if (long_hit || jab_hit) st_d.isolated = 1'b1;

        if (dis_now) begin
            st_d.isolated = 1'b0;
            st_d.cc       = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign isolated = st_q.isolated;
    assign rx_gate  = !st_q.isolated;

    assert_jab100_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_100 && jabber && !part_dis_100) |=> isolated);

    assert_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_100 ? part_dis_100 : part_dis_10) |=> !isolated);

    assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isolated) |-> $past(st_q.saw_col || collision || (speed_100 && jabber)));

    assert_fall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(isolated) |-> $past(dis_now || (pkt_end && !st_q.saw_col)));
endmodule

// File: tb/port_isolation_fsm_tb_top.sv
module port_isolation_fsm_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b1;
    logic carrier = 1'b0, port_tx = 1'b0, collision = 1'b0, jabber = 1'b0;
    logic speed_100 = 1'b0, limit_x2_10 = 1'b0, limit_x2_100 = 1'b0;
    logic part_dis_10 = 1'b0, part_dis_100 = 1'b0;
    logic isolated, rx_gate;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    port_isolation_fsm dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .carrier(carrier),
        .port_tx(port_tx), .collision(collision), .jabber(jabber),
        .speed_100(speed_100), .limit_x2_10(limit_x2_10), .limit_x2_100(limit_x2_100),
        .part_dis_10(part_dis_10), .part_dis_100(part_dis_100),
        .isolated(isolated), .rx_gate(rx_gate)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic spd);
        @(negedge clk);
        rst_n = 1'b0; carrier = 0; port_tx = 0; collision = 0; jabber = 0;
        bit_tick = 1; limit_x2_10 = 0; limit_x2_100 = 0;
        part_dis_10 = 0; part_dis_100 = 0; speed_100 = spd;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_pkt(input int n, input logic col, input logic use_tx);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            carrier = !use_tx; port_tx = use_tx; collision = col;
        end
        @(negedge clk);
        carrier = 0; port_tx = 0; collision = 0;
        @(negedge clk);
    endtask

    task automatic col_pkts(input int cnt);
        for (int i = 0; i < cnt; i++) send_pkt(4, 1'b1, 1'b0);
    endtask

    task automatic t_reset_r1;
        do_reset(1'b0);
        chk("R1 isolated after reset", isolated, 1'b0);
        chk("R1 rx_gate after reset", rx_gate, 1'b1);
    endtask

    task automatic t_limits_r2;
        do_reset(1'b0);
        col_pkts(31);
        chk("R2 10M 31 collisions", isolated, 1'b0);
        col_pkts(1);
        chk("R2 10M 32 collisions", isolated, 1'b1);
        chk("R8 rx_gate while isolated", rx_gate, 1'b0);
        do_reset(1'b1);
        col_pkts(63);
        chk("R2 100M 63 collisions", isolated, 1'b0);
        col_pkts(1);
        chk("R2 100M 64 collisions", isolated, 1'b1);
    endtask

    task automatic t_doubled_r3;
        do_reset(1'b0);
        limit_x2_10 = 1; limit_x2_100 = 0;
        col_pkts(63);
        chk("R3 10M x2 63 collisions", isolated, 1'b0);
        col_pkts(1);
        chk("R3 10M x2 64 collisions", isolated, 1'b1);
        do_reset(1'b1);
        limit_x2_100 = 1;
        col_pkts(127);
        chk("R3 100M x2 127 collisions", isolated, 1'b0);
        col_pkts(1);
        chk("R3 100M x2 128 collisions", isolated, 1'b1);
        do_reset(1'b1);
        limit_x2_10 = 1;
        col_pkts(64);
        chk("R3 10M doubling ignored at 100M", isolated, 1'b1);
    endtask

    task automatic t_clear_r4;
        do_reset(1'b0);
        col_pkts(31);
        send_pkt(8, 1'b0, 1'b0);
        col_pkts(31);
        chk("R4 clean packet cleared count", isolated, 1'b0);
        col_pkts(1);
        chk("R4 count restarts then reaches limit", isolated, 1'b1);
    endtask

    task automatic t_long_r5;
        do_reset(1'b0);
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk); carrier = 1; collision = 1;
        end
        @(negedge clk);
        chk("R5 1024 strobes of collision", isolated, 1'b0);
        @(negedge clk);
        chk("R5 1025th strobe isolates", isolated, 1'b1);
        carrier = 0; collision = 0;
        @(negedge clk);
    endtask

    task automatic t_jabber_r6;
        do_reset(1'b1);
        @(negedge clk); jabber = 1;
        @(negedge clk);
        chk("R6 jabber at 100M isolates", isolated, 1'b1);
        jabber = 0;
        do_reset(1'b0);
        @(negedge clk); jabber = 1; carrier = 1;
        repeat (10) @(negedge clk);
        chk("R6 jabber at 10M ignored", isolated, 1'b0);
        jabber = 0; carrier = 0;
        @(negedge clk);
    endtask

    task automatic t_reconnect_r7;
        do_reset(1'b0);
        col_pkts(32);
        chk("R7 isolated before reconnect", isolated, 1'b1);
        send_pkt(600, 1'b1, 1'b0);
        chk("R7 long collided packet keeps isolation", isolated, 1'b1);
        send_pkt(512, 1'b0, 1'b0);
        chk("R7 512-strobe clean packet keeps isolation", isolated, 1'b1);
        chk("R8 rx_gate low while isolated", rx_gate, 1'b0);
        send_pkt(513, 1'b0, 1'b1);
        chk("R7 513-strobe clean transmit reconnects", isolated, 1'b0);
        chk("R8 rx_gate high after reconnect", rx_gate, 1'b1);
    endtask

    task automatic t_disable_r9;
        do_reset(1'b0);
        part_dis_10 = 1;
        col_pkts(40);
        chk("R9 10M disable blocks isolation", isolated, 1'b0);
        do_reset(1'b1);
        part_dis_10 = 1;
        col_pkts(64);
        chk("R9 10M disable ignored at 100M", isolated, 1'b1);
        do_reset(1'b1);
        part_dis_100 = 1;
        @(negedge clk); jabber = 1;
        @(negedge clk);
        chk("R9 100M disable blocks jabber isolation", isolated, 1'b0);
        jabber = 0;
    endtask

    task automatic t_tick_r10;
        do_reset(1'b0);
        for (int i = 0; i < 1100; i++) begin
            @(negedge clk); carrier = 1; collision = 1; bit_tick = i[0];
        end
        @(negedge clk);
        chk("R10 half-rate strobe counts 550 bit times", isolated, 1'b0);
        carrier = 0; collision = 0; bit_tick = 1;
        @(negedge clk);
    endtask

    initial begin
        t_reset_r1();
        t_limits_r2();
        t_doubled_r3();
        t_clear_r4();
        t_long_r5();
        t_jabber_r6();
        t_reconnect_r7();
        t_disable_r9();
        t_tick_r10();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule